// File: doc/BRIEF.md
# DMA Interrupt Status Register Bank

This block keeps the interrupt state of an eight-channel DMA controller. The channel engines send it one-cycle pulses when a channel reaches its terminal count or hits an error. The block also receives pulses that mark a channel as enabled or finished. Each interrupt class has a sticky pending bit per channel and a per-channel mask. From these the block forms masked status and one registered combined interrupt line per class.

Software reaches the bank through a 32-bit register port with a word address, a synchronous write strobe and a read strobe. Read data appears on the clock after the strobe. Pending bits are cleared by writing ones to a clear register. The enabled-channel view is read-only: a start pulse sets a channel's bit and a completion pulse clears it again.

Top module: `dma_irq_bank`

## Requirements
- R1: A synchronous active-high `rst` clears all pending, mask and enabled bits and both interrupt outputs. Every register then reads 0.
- R2: A 1 on `tc_pulse[i]` sets the raw terminal-count bit i at that clock edge. The bit stays set until it is cleared, and it reads back in bit i of address 4.
- R3: A 1 on `err_pulse[i]` sets the raw error bit i at that clock edge. The bit stays set until it is cleared, and it reads back in bit i of address 5.
- R4: The masks are read-write: address 7 holds the terminal-count mask and address 8 holds the error mask, and a mask bit of 1 lets the channel through. Address 0 reads the raw terminal-count bits ANDed with their mask. Address 1 reads the raw error bits ANDed with their mask.
- R5: Writing to address 2 clears each raw terminal-count bit whose `wdata` bit is 1. Writing to address 3 does the same for raw error bits. Bits written as 0 are left unchanged.
- R6: If an event pulse and a clear write reach the same bit in the same cycle, the bit ends up set.
- R7: Address 6 reads the enabled channels. `ch_en_set[i]` sets bit i and `ch_done[i]` clears it. If both arrive in the same cycle, the bit ends up set.
- R8: Bits 31:8 of every read are 0, and writes to them are ignored. The clear registers read 0, and so do addresses 9 to 15.
- R9: `irq_tc` is the OR of the masked terminal-count bits and `irq_err` is the OR of the masked error bits. Each output changes one clock after the status it reflects.
- R10: `rdata` takes the addressed register's value at the clock edge where `rd_en` is 1. It holds that value while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after rd_en |
| tc_pulse | input | 8 | Per-channel terminal-count event |
| err_pulse | input | 8 | Per-channel error event |
| ch_en_set | input | 8 | Per-channel enable pulse |
| ch_done | input | 8 | Per-channel completion pulse |
| irq_tc | output | 1 | Combined terminal-count interrupt |
| irq_err | output | 1 | Combined error interrupt |

## Verification
The bench sweeps all 256 mask values against fixed raw patterns in both interrupt classes. A design with a mask of inverted polarity, or with the two classes crossed, would give wrong masked words or a wrong interrupt level. The bench drives an event and a clear at the same bit in one cycle, and a start and a completion at the same channel in one cycle. A design that gives priority to the clear would lose the event, and one that gives priority to completion would drop the channel. It also checks that the combined interrupt is still low one cycle after the status changes and high the cycle after that, which catches an output that is combinational or one cycle late. Writes of all ones and reads of unmapped addresses expose any reserved bit that is stored or driven.

// File: rtl/dma_irq_bank.sv
module dma_irq_bank #(
  parameter int NCH = 8,
  parameter int AW  = 4,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NCH-1:0] tc_pulse,
  input  logic [NCH-1:0] err_pulse,
  input  logic [NCH-1:0] ch_en_set,
  input  logic [NCH-1:0] ch_done,
  output logic          irq_tc,
  output logic          irq_err
);

  localparam logic [AW-1:0] A_MTC  = AW'(0);
  localparam logic [AW-1:0] A_MERR = AW'(1);
  localparam logic [AW-1:0] A_CTC  = AW'(2);
  localparam logic [AW-1:0] A_CERR = AW'(3);
  localparam logic [AW-1:0] A_RTC  = AW'(4);
  localparam logic [AW-1:0] A_RERR = AW'(5);
  localparam logic [AW-1:0] A_EN   = AW'(6);
  localparam logic [AW-1:0] A_KTC  = AW'(7);
  localparam logic [AW-1:0] A_KERR = AW'(8);

  logic [NCH-1:0] tc_raw, err_raw, tc_mask, err_mask, en_q;
  logic [NCH-1:0] tc_clr, err_clr, wbits;
  logic [DW-1:0]  rd_word;

  assign wbits   = wdata[NCH-1:0];
  assign tc_clr  = (wr_en && addr == A_CTC)  ? wbits : '0;
  assign err_clr = (wr_en && addr == A_CERR) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_raw   <= '0;
      err_raw  <= '0;
      tc_mask  <= '0;
      err_mask <= '0;
      en_q     <= '0;
      irq_tc   <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      tc_raw  <= (tc_raw  & ~tc_clr)  | tc_pulse;
      err_raw <= (err_raw & ~err_clr) | err_pulse;
      en_q    <= (en_q & ~ch_done) | ch_en_set;
      if (wr_en && addr == A_KTC)  tc_mask  <= wbits;
      if (wr_en && addr == A_KERR) err_mask <= wbits;
      irq_tc  <= |(tc_raw & tc_mask);
      irq_err <= |(err_raw & err_mask);
    end
  end

  always_comb begin
    rd_word = '0;
    case (addr)
      A_MTC:   rd_word[NCH-1:0] = tc_raw & tc_mask;
      A_MERR:  rd_word[NCH-1:0] = err_raw & err_mask;
      A_RTC:   rd_word[NCH-1:0] = tc_raw;
      A_RERR:  rd_word[NCH-1:0] = err_raw;
      A_EN:    rd_word[NCH-1:0] = en_q;
      A_KTC:   rd_word[NCH-1:0] = tc_mask;
      A_KERR:  rd_word[NCH-1:0] = err_mask;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

endmodule

// File: rtl/dma_irq_bank_chk.sv
module dma_irq_bank_chk #(
  parameter int NCH = 8,
  parameter int AW  = 4,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic [AW-1:0]  addr,
  input logic [DW-1:0]  wdata,
  input logic [DW-1:0]  rdata,
  input logic [NCH-1:0] tc_pulse,
  input logic [NCH-1:0] err_pulse,
  input logic [NCH-1:0] ch_en_set,
  input logic [NCH-1:0] ch_done,
  input logic           irq_tc,
  input logic           irq_err,
  input logic [NCH-1:0] tc_raw,
  input logic [NCH-1:0] err_raw,
  input logic [NCH-1:0] tc_mask,
  input logic [NCH-1:0] err_mask,
  input logic [NCH-1:0] en_q
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tc_raw == '0 && err_raw == '0 && en_q == '0 && !irq_tc && !irq_err));

  assert_tc_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (|tc_pulse) |=> ((tc_raw & $past(tc_pulse)) == $past(tc_pulse)));

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (|err_pulse) |=> ((err_raw & $past(err_pulse)) == $past(err_pulse)));

  assert_tc_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(2)) |=> ((tc_raw & $past(wdata[NCH-1:0] & ~tc_pulse)) == '0));

  assert_done_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (|(ch_done & ~ch_en_set)) |=> ((en_q & $past(ch_done & ~ch_en_set)) == '0));

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
    rdata[DW-1:NCH] == '0);

  assert_irq_tc_delay_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_tc == $past(|(tc_raw & tc_mask))));

  assert_irq_err_delay_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_err == $past(|(err_raw & err_mask))));

endmodule

bind dma_irq_bank dma_irq_bank_chk #(.NCH(NCH), .AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
  .tc_pulse(tc_pulse), .err_pulse(err_pulse), .ch_en_set(ch_en_set), .ch_done(ch_done),
  .irq_tc(irq_tc), .irq_err(irq_err), .tc_raw(tc_raw), .err_raw(err_raw),
  .tc_mask(tc_mask), .err_mask(err_mask), .en_q(en_q)
);

// File: tb/dma_irq_bank_tb_top.sv
module dma_irq_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  tc_pulse = '0, err_pulse = '0, ch_en_set = '0, ch_done = '0;
  logic        irq_tc, irq_err;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  dma_irq_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tc_pulse(tc_pulse), .err_pulse(err_pulse), .ch_en_set(ch_en_set),
    .ch_done(ch_done), .irq_tc(irq_tc), .irq_err(irq_err)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] tc, input logic [7:0] er);
    @(negedge clk); tc_pulse = tc; err_pulse = er;
    @(negedge clk); tc_pulse = '0; err_pulse = '0;
  endtask

  logic [31:0] d;
  logic [7:0]  exp_raw;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: everything reads zero after reset
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk("R1 reset read", d, 32'h0);
    end
    chk("R1 irq_tc", {31'h0, irq_tc}, 32'h0);
    chk("R1 irq_err", {31'h0, irq_err}, 32'h0);

    // R2 / R3: per-channel event accumulation
    exp_raw = '0;
    for (int i = 0; i < 8; i++) begin
      pulse(8'(1 << i), 8'h0);
      exp_raw = exp_raw | 8'(1 << i);
      rd(4'd4, d); chk("R2 raw tc", d, {24'h0, exp_raw});
      rd(4'd5, d); chk("R3 raw err untouched", d, 32'h0);
    end
    exp_raw = '0;
    for (int i = 7; i >= 0; i--) begin
      pulse(8'h0, 8'(1 << i));
      exp_raw = exp_raw | 8'(1 << i);
      rd(4'd5, d); chk("R3 raw err", d, {24'h0, exp_raw});
    end

    // R5: zero writes have no effect, ones clear
    wr(4'd2, 32'h0); rd(4'd4, d); chk("R5 tc clear zeros", d, 32'hFF);
    wr(4'd2, 32'h0F); rd(4'd4, d); chk("R5 tc clear low", d, 32'hF0);
    rd(4'd5, d); chk("R5 err kept", d, 32'hFF);
    wr(4'd3, 32'h3C); rd(4'd5, d); chk("R5 err clear", d, 32'hC3);
    wr(4'd2, 32'hFF); wr(4'd3, 32'hFF);
    rd(4'd4, d); chk("R5 tc all clear", d, 32'h0);
    rd(4'd5, d); chk("R5 err all clear", d, 32'h0);

    // R4 / R9: full mask sweep on both classes
    pulse(8'hA5, 8'h5A);
    for (int m = 0; m < 256; m++) begin
      wr(4'd7, 32'(m)); wr(4'd8, 32'(255 - m));
      rd(4'd0, d); chk("R4 masked tc", d, 32'(8'hA5 & 8'(m)));
      rd(4'd1, d); chk("R4 masked err", d, 32'(8'h5A & 8'(255 - m)));
      chk("R9 irq_tc level", {31'h0, irq_tc}, {31'h0, |(8'hA5 & 8'(m))});
      chk("R9 irq_err level", {31'h0, irq_err}, {31'h0, |(8'h5A & 8'(255 - m))});
    end

    // R9: one-clock latency of the combined output
    wr(4'd2, 32'hFF); wr(4'd7, 32'h01);
    @(negedge clk);
    chk("R9 tc idle", {31'h0, irq_tc}, 32'h0);
    tc_pulse = 8'h01;
    @(negedge clk); tc_pulse = '0;
    chk("R9 not yet", {31'h0, irq_tc}, 32'h0);
    @(negedge clk);
    chk("R9 asserted", {31'h0, irq_tc}, 32'h1);

    // R6: event beats simultaneous clear
    wr(4'd2, 32'hFF); pulse(8'h18, 8'h00);
    @(negedge clk); addr = 4'd2; wdata = 32'h18; wr_en = 1'b1; tc_pulse = 8'h08;
    @(negedge clk); wr_en = 1'b0; tc_pulse = '0;
    rd(4'd4, d); chk("R6 tc event wins", d, 32'h08);
    wr(4'd3, 32'hFF); pulse(8'h00, 8'h81);
    @(negedge clk); addr = 4'd3; wdata = 32'hFF; wr_en = 1'b1; err_pulse = 8'h80;
    @(negedge clk); wr_en = 1'b0; err_pulse = '0;
    rd(4'd5, d); chk("R6 err event wins", d, 32'h80);

    // R7: enabled channel tracking
    @(negedge clk); ch_en_set = 8'hF3;
    @(negedge clk); ch_en_set = '0;
    rd(4'd6, d); chk("R7 enabled set", d, 32'hF3);
    @(negedge clk); ch_done = 8'h21;
    @(negedge clk); ch_done = '0;
    rd(4'd6, d); chk("R7 done clears", d, 32'hD2);
    @(negedge clk); ch_done = 8'h42; ch_en_set = 8'h40;
    @(negedge clk); ch_done = '0; ch_en_set = '0;
    rd(4'd6, d); chk("R7 set beats done", d, 32'hD0);
    wr(4'd6, 32'hFF); rd(4'd6, d); chk("R7 read-only", d, 32'hD0);

    // R8: reserved bits and unmapped addresses
    wr(4'd7, 32'hFFFF_FFFF); rd(4'd7, d); chk("R8 mask reserved", d, 32'hFF);
    rd(4'd2, d); chk("R8 clear reg reads zero", d, 32'h0);
    rd(4'd3, d); chk("R8 clear reg reads zero", d, 32'h0);
    for (int a = 9; a < 16; a++) begin
      wr(4'(a), 32'hFFFF_FFFF);
      rd(4'(a), d); chk("R8 unmapped", d, 32'h0);
    end

    // R10: rdata holds without a read strobe
    rd(4'd6, d); chk("R10 read", d, 32'hD0);
    @(negedge clk); ch_en_set = 8'h0C; addr = 4'd6;
    @(negedge clk); ch_en_set = '0;
    @(negedge clk);
    chk("R10 hold", rdata, 32'hD0);
    rd(4'd6, d); chk("R10 refresh", d, 32'hDC);

    // R1: reset again clears state set above
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(4'd6, d); chk("R1 enabled cleared", d, 32'h0);
    rd(4'd7, d); chk("R1 mask cleared", d, 32'h0);
    rd(4'd4, d); chk("R1 raw cleared", d, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule